// File: doc/BRIEF.md
# Timer Capture Channel

This block is one channel of a 16-bit timer/counter used to measure external signals. It counts active edges of a selectable counting clock. That clock is a single-cycle enable derived from the system clock by a fixed prescaler. The channel snapshots the running count into two capture registers, A and B, when chosen edges appear on capture line A. Line A is the OR of an input pin and a peripheral event input. Typical measurements are period, pulse width and duty cycle.

Several trigger sources restart the count from zero:
- a per-channel software strobe,
- a global synchronisation strobe shared by all channels,
- a compare match against a programmable reload value (RC),
- an edge on line A or line B.

A trigger never acts at once. It is held pending and applied at the next active edge of the counting clock. With a slow clock, the counter can therefore still read its old value for many system cycles after the trigger.

Two write strobes load the mode word and the RC value. The counter, both capture registers and a small status word are always visible on output ports. A status-read strobe clears the sticky overflow flag.

Top module: `tc_capture_chan`

## Requirements
- R1: After reset the counter, RA, RB and the status word (bit0 overflow, bit1 running, bit2 RA-armed) are all zero. The counter stays at zero until the first trigger.
- R2: A pulse on `sw_trig` or `sync_trig` sets the counter to zero and sets the running bit at the next counting tick. Each later tick adds one.
- R3: `clk_sel` chooses the tick rate: 00 every system cycle, 01 every 2nd, 10 every 8th, 11 every 32nd. A pending trigger waits for the next tick, and between ticks the count holds.
- R4: When mode bit 5 (RC trigger enable) is set and a tick arrives while the count equals RC, the next count is zero. With the bit clear, counting continues past RC.
- R5: When mode bit 6 is set, an edge on the line chosen by mode bit 7 (0 line A, 1 line B) triggers the channel. The edge type is given by mode bits [9:8] (00 none, 01 rising, 10 falling, 11 both). With `clk_sel` 00, a pin change made before system edge N shows a zero count after edge N+2.
- R6: Line A is the OR of `pin_a` and `evt_a`, so either input alone drives captures.
- R7: Mode bits [2:1] select the RA load edge of line A (00 none, 01 rising, 10 falling, 11 both). A pin change made before system edge N loads RA at edge N+2 with the count present after edge N+1.
- R8: Mode bits [4:3] select the RB load edge with the same encoding. RB loads only if RA has loaded since the last trigger, and that condition is reported in status bit 2.
- R9: A tick at count 0xFFFF wraps the counter to zero and sets status bit 0. The bit stays set until a `stat_rd` pulse clears it, and a new overflow in the same cycle wins.
- R10: Mode bit 0 set to 1 (waveform mode) blocks both captures and the external trigger. Software, sync and RC triggers keep working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Counting clock rate select |
| pin_a | input | 1 | Line A pin, asynchronous |
| evt_a | input | 1 | Peripheral event ORed into line A |
| pin_b | input | 1 | Line B pin, asynchronous |
| sw_trig | input | 1 | Software trigger strobe |
| sync_trig | input | 1 | Global synchronisation strobe |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 10 | Mode word data |
| rc_wr | input | 1 | Write strobe for RC |
| rc_wdata | input | 16 | RC data |
| stat_rd | input | 1 | Status read strobe, clears overflow |
| cnt_o | output | 16 | Counter value |
| ra_o | output | 16 | Capture register A |
| rb_o | output | 16 | Capture register B |
| status_o | output | 3 | {RA-armed, running, overflow} |

## Verification
The bench places a trigger just after a tick of the slowest clock. A design that applies triggers at once would show zero 31 cycles too early. Capture vectors use RB edges that come before any RA load. A design without the RA-before-RB gate would fill RB there, and one that mishandles the both-edges case would load the rising count where the falling count belongs. The bench runs the counter through 0xFFFF to catch a wrong wrap or a flag that is not sticky. It also drives line A and line B in waveform mode, where a missing mode gate shows up as a loaded RA or a restarted count.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the timer capture channel.
// Assumes: the mode word layout below is the software-visible encoding.
package tcc_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Mode word, MSB first: bits [9:8] .. bit 0.
    typedef struct packed {
        edge_sel_e ext_edge;    // [9:8] external trigger edge
        logic      ext_sel;     // [7]   0 line A, 1 line B
        logic      ext_en;      // [6]   external trigger enable
        logic      rc_trig_en;  // [5]   RC compare restart enable
        edge_sel_e rb_edge;     // [4:3] RB load edge
        edge_sel_e ra_edge;     // [2:1] RA load edge
        logic      wave;        // [0]   1 = waveform mode (capture off)
    } mode_t;

    localparam int MODE_W  = $bits(mode_t);
    localparam int PRESC_W = 5;      // enough for the /32 setting

    // True when the detected edge matches the programmed selection.
    function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
        return ((sel == EDGE_RISE) && rise) ||
               ((sel == EDGE_FALL) && fall) ||
               ((sel == EDGE_BOTH) && (rise || fall));
    endfunction

    // Prescaler shift for each clock select code: /1, /2, /8, /32.
    function automatic int div_shift(logic [1:0] sel);
        return (sel == 2'd0) ? 0 : (2 * int'(sel) - 1);
    endfunction

endpackage

// File: rtl/tcc_sync_edge.sv
`timescale 1ns/1ps
// Module: multi-bit synchroniser with edge detection.
// Each asynchronous input passes a STAGES-deep flop chain, and a final
// flop holds the previous synchronised level so rise and fall pulses last
// one system cycle. Assumes: inputs stay stable for at least one clock.
module tcc_sync_edge #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] din,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);

    for (genvar g = 0; g < N_IN; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Shift the raw input through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], din[g]};
        end

        // Remember the last synchronised level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= chain_q[STAGES-1];
        end

        // Single-cycle edge pulses.
        always_comb begin
            rise[g] =  chain_q[STAGES-1] & ~prev_q;
            fall[g] = ~chain_q[STAGES-1] &  prev_q;
        end
    end

endmodule

// File: rtl/tcc_tick_gen.sv
`timescale 1ns/1ps
// Module: counting clock enable generator.
// A free-running prescaler runs from reset. The tick is high whenever the
// low bits chosen by clk_sel are all ones. Assumes: clk_sel may change at
// any time, and the phase after a change is not defined.
module tcc_tick_gen
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    output logic       tick
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;

    // Free-running prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    // Mask from the select code, then the tick compare.
    always_comb begin
        mask = PRESC_W'((1 << div_shift(clk_sel)) - 1);
        tick = ((presc_q & mask) == mask);
    end

    AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'd0) |-> tick);  // R3

endmodule

// File: rtl/tcc_count_core.sv
`timescale 1ns/1ps
// Module: counter, trigger pending latch, run flag and overflow flag.
// A trigger request is held until the next tick and then zeroes the counter
// and sets the run flag. While running, each tick increments the counter,
// reloads zero on an RC match (if enabled) or wraps at the maximum.
// Assumes: trig_req is a single-cycle or level request in the clk domain.
module tcc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig_req,
    input  logic             rc_en,
    input  logic [CNT_W-1:0] rc_val,
    input  logic             stat_rd,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             ovf,
    output logic             restart
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             pend_q;
    logic             run_q;
    logic             ovf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    logic             rc_hit;
    logic             wrap;

    // Decode this cycle's counter action.
    always_comb begin
        take    = tick & (pend_q | trig_req);
        rc_hit  = run_q & rc_en & (cnt_q == rc_val);
        wrap    = tick & run_q & ~take & ~rc_hit & (cnt_q == CNT_MAX);
        restart = take | (tick & rc_hit);
    end

    // Hold a trigger request until a tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q | trig_req) & ~tick;
    end

    // The run flag is set by the first applied trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 1'b0;
        else if (take) run_q <= 1'b1;
    end

    // Counter update on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= '0;
        end else if (tick && run_q) begin
            if (rc_hit || (cnt_q == CNT_MAX)) cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky overflow; a new wrap wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (stat_rd) ovf_q <= 1'b0;
    end

    assign cnt     = cnt_q;
    assign running = run_q;
    assign ovf     = ovf_q;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !take) |=> $stable(cnt_q));  // R1
    AST_TRIG_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cnt_q == '0) && run_q);  // R2
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));  // R3
    AST_RC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rc_hit) |=> (cnt_q == '0));  // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !stat_rd) |=> ovf_q);  // R9

endmodule

// File: rtl/tcc_capture.sv
`timescale 1ns/1ps
// Module: RA and RB capture registers with the RA-before-RB gate.
// RA loads the count on its selected edge of line A. RB loads on its edge
// only after RA has loaded since the last restart. Assumes: rise/fall are
// single-cycle pulses and en is low in waveform mode.
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             a_rise,
    input  logic             a_fall,
    input  edge_sel_e        ra_edge,
    input  edge_sel_e        rb_edge,
    input  logic [CNT_W-1:0] cnt,
    input  logic             restart,
    output logic [CNT_W-1:0] ra,
    output logic [CNT_W-1:0] rb,
    output logic             ra_armed
);

    logic [CNT_W-1:0] ra_q;
    logic [CNT_W-1:0] rb_q;
    logic             armed_q;
    logic             ra_load;
    logic             rb_load;

    // Load decisions for this cycle.
    always_comb begin
        ra_load = en & edge_match(ra_edge, a_rise, a_fall);
        rb_load = en & armed_q & edge_match(rb_edge, a_rise, a_fall);
    end

    // Capture register A.
    always_ff @(posedge clk) begin
        if (!rst_n)       ra_q <= '0;
        else if (ra_load) ra_q <= cnt;
    end

    // Capture register B.
    always_ff @(posedge clk) begin
        if (!rst_n)       rb_q <= '0;
        else if (rb_load) rb_q <= cnt;
    end

    // Armed flag: set by an RA load, cleared by any restart (restart wins).
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (restart) armed_q <= 1'b0;
        else if (ra_load) armed_q <= 1'b1;
    end

    assign ra       = ra_q;
    assign rb       = rb_q;
    assign ra_armed = armed_q;

    AST_RB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> $stable(rb_q));  // R8

endmodule

// File: rtl/tc_capture_chan.sv
`timescale 1ns/1ps
// Module: timer channel in capture mode (top).
// Holds the mode word and RC value, merges the trigger sources, builds
// line A from pin and event, and wires the tick generator, synchroniser,
// counter core and capture registers. Assumes: sw_trig and sync_trig are
// synchronous to clk, and the pins are asynchronous.
module tc_capture_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              pin_a,
    input  logic              evt_a,
    input  logic              pin_b,
    input  logic              sw_trig,
    input  logic              sync_trig,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              rc_wr,
    input  logic [CNT_W-1:0]  rc_wdata,
    input  logic              stat_rd,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  ra_o,
    output logic [CNT_W-1:0]  rb_o,
    output logic [2:0]        status_o
);

    localparam int LINE_A = 0;
    localparam int LINE_B = 1;

    mode_t            mode_q;
    logic [CNT_W-1:0] rc_q;
    logic [1:0]       line_raw;
    logic [1:0]       rise;
    logic [1:0]       fall;
    logic             tick;
    logic             ext_hit;
    logic             trig_req;
    logic             restart;
    logic             running;
    logic             ovf;
    logic             armed;

    // Mode word register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_t'(mode_wdata);
    end

    // RC compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rc_q <= '0;
        else if (rc_wr) rc_q <= rc_wdata;
    end

    // Line A merges pin and event before synchronisation.
    always_comb begin
        line_raw[LINE_A] = pin_a | evt_a;
        line_raw[LINE_B] = pin_b;
    end

    // External trigger decode and trigger source merge.
    always_comb begin
        ext_hit  = ~mode_q.wave & mode_q.ext_en &
                   edge_match(mode_q.ext_edge,
                              mode_q.ext_sel ? rise[LINE_B] : rise[LINE_A],
                              mode_q.ext_sel ? fall[LINE_B] : fall[LINE_A]);
        trig_req = sw_trig | sync_trig | ext_hit;
    end

    tcc_sync_edge #(
        .N_IN   (2),
        .STAGES (STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_raw),
        .rise  (rise),
        .fall  (fall)
    );

    tcc_tick_gen i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    tcc_count_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .trig_req (trig_req),
        .rc_en    (mode_q.rc_trig_en),
        .rc_val   (rc_q),
        .stat_rd  (stat_rd),
        .cnt      (cnt_o),
        .running  (running),
        .ovf      (ovf),
        .restart  (restart)
    );

    tcc_capture #(
        .CNT_W (CNT_W)
    ) i_capt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~mode_q.wave),
        .a_rise   (rise[LINE_A]),
        .a_fall   (fall[LINE_A]),
        .ra_edge  (mode_q.ra_edge),
        .rb_edge  (mode_q.rb_edge),
        .cnt      (cnt_o),
        .restart  (restart),
        .ra       (ra_o),
        .rb       (rb_o),
        .ra_armed (armed)
    );

    assign status_o = {armed, running, ovf};

    AST_WAVE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.wave |=> ($stable(ra_o) && $stable(rb_o)));  // R10

endmodule

// File: tb/test_tc_capture_chan.sv
`timescale 1ns/1ps
module test_tc_capture_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        pin_a = 1'b0, evt_a = 1'b0, pin_b = 1'b0;
    logic        sw_trig = 1'b0, sync_trig = 1'b0;
    logic        mode_wr = 1'b0, rc_wr = 1'b0, stat_rd = 1'b0;
    logic [9:0]  mode_wdata = '0;
    logic [15:0] rc_wdata = '0;
    logic [15:0] cnt_o, ra_o, rb_o;
    logic [2:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    tc_capture_chan i_tc_capture_chan (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .pin_a(pin_a), .evt_a(evt_a), .pin_b(pin_b),
        .sw_trig(sw_trig), .sync_trig(sync_trig),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .rc_wr(rc_wr), .rc_wdata(rc_wdata), .stat_rd(stat_rd),
        .cnt_o(cnt_o), .ra_o(ra_o), .rb_o(rb_o), .status_o(status_o)
    );

    typedef struct packed {
        logic [1:0]  ra_e;
        logic [1:0]  rb_e;
        logic        use_evt;
        logic [3:0]  d1;
        logic [3:0]  d2;
        logic [15:0] exp_ra;
        logic [15:0] exp_rb;
        logic        exp_arm;
    } vec_t;

    // Rising edge captures count d1+2, falling edge captures d1+d2+2.
    localparam vec_t VECS [8] = '{
        '{2'b01, 2'b10, 1'b0, 4'd3, 4'd5, 16'd5,  16'd10, 1'b1},
        '{2'b10, 2'b01, 1'b0, 4'd3, 4'd5, 16'd10, 16'd0,  1'b1},
        '{2'b11, 2'b11, 1'b0, 4'd3, 4'd5, 16'd10, 16'd10, 1'b1},
        '{2'b00, 2'b01, 1'b0, 4'd3, 4'd5, 16'd0,  16'd0,  1'b0},
        '{2'b01, 2'b01, 1'b1, 4'd3, 4'd5, 16'd5,  16'd0,  1'b1},
        '{2'b01, 2'b11, 1'b0, 4'd3, 4'd5, 16'd5,  16'd10, 1'b1},
        '{2'b11, 2'b10, 1'b0, 4'd0, 4'd1, 16'd3,  16'd3,  1'b1},
        '{2'b10, 2'b10, 1'b1, 4'd2, 4'd4, 16'd8,  16'd0,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pin_a = 0; evt_a = 0; pin_b = 0; clk_sel = 2'd0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr_mode(input logic [9:0] m);
        mode_wdata = m; mode_wr = 1'b1; step(1); mode_wr = 1'b0;
    endtask

    task automatic wr_rc(input logic [15:0] v);
        rc_wdata = v; rc_wr = 1'b1; step(1); rc_wr = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; step(1); sw_trig = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] old;
        step(1);
        do_reset();
        step(1);
        // R1: reset state and stopped counter
        chk("R1 cnt", cnt_o, 0);
        chk("R1 ra", ra_o, 0);
        chk("R1 rb", rb_o, 0);
        chk("R1 status", status_o, 0);
        step(10);
        chk("R1 stopped", cnt_o, 0);

        // R2: software trigger starts counting
        pulse_sw();
        chk("R2 zero", cnt_o, 0);
        chk("R2 running", status_o[1], 1);
        step(7);
        chk("R2 count", cnt_o, 7);
        // R2: sync strobe restarts like a software trigger
        sync_trig = 1'b1; step(1); sync_trig = 1'b0;
        chk("R2 sync zero", cnt_o, 0);
        step(3);
        chk("R2 sync count", cnt_o, 3);

        // Capture vectors: R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr_mode({5'b0, VECS[i].rb_e, VECS[i].ra_e, 1'b0});
            pulse_sw();
            step(int'(VECS[i].d1));
            if (VECS[i].use_evt) evt_a = 1'b1; else pin_a = 1'b1;
            step(int'(VECS[i].d2));
            evt_a = 1'b0; pin_a = 1'b0;
            step(4);
            chk($sformatf("R7 ra vec%0d", i), ra_o, VECS[i].exp_ra);
            chk($sformatf("R8 rb vec%0d", i), rb_o, VECS[i].exp_rb);
            chk($sformatf("R8 armed vec%0d", i), status_o[2], VECS[i].exp_arm);
        end

        // R4: RC compare restart
        do_reset();
        wr_rc(16'd5);
        wr_mode(10'h020);
        pulse_sw();
        step(5);
        chk("R4 at rc", cnt_o, 5);
        step(1);
        chk("R4 reload", cnt_o, 0);
        step(1);
        chk("R4 after", cnt_o, 1);
        wr_mode(10'h000);
        pulse_sw();
        step(6);
        chk("R4 disabled", cnt_o, 6);

        // R5: external trigger on line B rising edge
        do_reset();
        wr_mode(10'h1C0);
        pulse_sw();
        step(10);
        pin_b = 1'b1;
        step(2);
        chk("R5 not yet", cnt_o, 12);
        step(1);
        chk("R5 zero", cnt_o, 0);
        step(1);
        chk("R5 count", cnt_o, 1);
        pin_b = 1'b0;
        step(5);
        chk("R5 fall ignored", cnt_o, 6);

        // R10: waveform mode blocks capture and external trigger
        do_reset();
        wr_mode(10'h1C3);
        pulse_sw();
        step(2);
        pin_a = 1'b1; pin_b = 1'b1;
        step(6);
        chk("R10 no ext trig", cnt_o, 8);
        chk("R10 no ra", ra_o, 0);
        chk("R10 not armed", status_o[2], 0);
        pulse_sw();
        chk("R10 sw still", cnt_o, 0);

        // R3: trigger waits for the slow tick
        do_reset();
        wr_mode(10'h000);
        pulse_sw();
        step(10);
        clk_sel = 2'd3;
        old = cnt_o;
        for (int k = 0; k < 40; k++) begin
            step(1);
            if (cnt_o != old) break;
        end
        old = cnt_o;
        chk("R3 ticked", old, 11);
        pulse_sw();
        chk("R3 held", cnt_o, old);
        step(30);
        chk("R3 still held", cnt_o, old);
        step(1);
        chk("R3 applied", cnt_o, 0);
        step(32);
        chk("R3 slow count", cnt_o, 1);
        clk_sel = 2'd0;

        // R9: overflow wrap and sticky flag
        do_reset();
        wr_mode(10'h000);
        pulse_sw();
        step(65535);
        chk("R9 max", cnt_o, 16'hFFFF);
        chk("R9 no ovf", status_o[0], 0);
        step(1);
        chk("R9 wrap", cnt_o, 0);
        chk("R9 ovf set", status_o[0], 1);
        step(3);
        chk("R9 sticky", status_o[0], 1);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R9 cleared", status_o[0], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule